// File: doc/BRIEF.md
# Burst Initiator Data-Phase Engine

This block is the data-transfer half of a master on a shared 32-bit bus whose handshake lines are active low. A local client asks for a burst by giving a word count, a direction and, for reads, a lane mask. The engine then runs one data phase per word. In each phase it drives the active-low lane enables and pulls its own ready line low. On writes it also drives the data. A phase is finished only on a clock edge where the target's ready line is low as well.

Write words come in through a valid/ready stream. Each word carries its own lane mask, and a mask with no lanes set is legal. Read words go back to the client with a one-cycle strobe, in the cycle after the phase that moved them. A wait-state setting makes the engine hold its ready line high for a chosen number of cycles before each phase. This lets the engine pace the bus, and it makes the case where the target is ready first easy to produce. When the last word has moved, a done pulse is given and the engine releases the bus.

Top module: `burst_initiator`

## Requirements
- R1: While reset is held and after it is released, the outputs are irdy_n=1, ad_oe=0, cbe_n=4'b1111, busy=0, done=0, rd_valid=0 and wr_ready=0.
- R2: While irdy_n is low, cbe_n holds the inverse of the current lane mask: the word's wr_be on a write, req_rd_be on a read. cbe_n bit i low enables data byte i, which is bits 8i+7 to 8i.
- R3: On a write, ad_out carries the word and ad_oe is 1 from the first cycle in which irdy_n is low. A word is taken from the stream (wr_valid and wr_ready both high) exactly at the edge where irdy_n goes low with it.
- R4: While irdy_n is low and trdy_n is high, the next cycle still has irdy_n low with ad_out and cbe_n unchanged.
- R5: A phase completes only at an edge where irdy_n and trdy_n are both low. A burst of req_len words completes exactly req_len phases, the words in stream order.
- R6: On a read, rd_data equals the ad_in value seen at the completing edge, and rd_valid is high exactly in the cycle after each completion and in no other cycle.
- R7: A word whose lane mask is 4'b0000 still runs a full phase with cbe_n=4'b1111, and it counts as one of the req_len words.
- R8: With wait_cfg=0 and write data always available, irdy_n stays low across back-to-back phases, and the next word is on ad_out in the cycle right after a completion.
- R9: After a non-final completion, when data is available, irdy_n is high for exactly wait_cfg cycles before it goes low for the next phase.
- R10: In the cycle after the final completion, done is high for one cycle, busy is 0, irdy_n is 1 and ad_oe is 0.
- R11: A request with req_len=0, or any request made while busy is 1, is ignored. Busy stays as it was, and the running burst moves neither more nor fewer words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a burst (taken only when idle) |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_len | input | 8 | Number of words in the burst |
| req_rd_be | input | 4 | Lane mask for all read phases, active high |
| wait_cfg | input | 4 | Wait cycles before each phase |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse after the final phase |
| wr_valid | input | 1 | Write word available |
| wr_ready | output | 1 | Write word taken this edge |
| wr_data | input | 32 | Write word |
| wr_be | input | 4 | Lane mask of the write word, active high |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | 32 | Read word |
| ad_out | output | 32 | Bus data driven by the engine |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 32 | Bus data as seen on the wires |
| cbe_n | output | 4 | Lane enables, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |

## Verification
Bursts of 1, 2 and 5 words are swept in both directions, with wait settings of 0, 1 and 3, against four target patterns. The patterns are always ready, alternating, ready one cycle in three, and pseudo-random. Always ready with a nonzero wait setting isolates the case where the target is ready before the engine. The alternating and sparse patterns exercise holding during target stalls. A separate sweep starves the write stream at random, which separates waiting for data from waiting for the wait counter. A zero-length request and a request made in mid-burst check that both are ignored. The target drives junk on ad_in whenever it is not ready, so any read word captured outside the completing edge shows up as a mismatch.

// File: rtl/bi_pkg.sv
package bi_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PHASE = 1'b1
    } bi_state_e;
endpackage

// File: rtl/bi_beat_counter.sv
module bi_beat_counter #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             step,
    output logic             last
);
    typedef struct packed {
        logic [LEN_W-1:0] left;
    } regs_t;

    regs_t cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.left = load_len;
        end else if (step && (cnt_q.left != '0)) begin
            cnt_d.left = cnt_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q.left == {{(LEN_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/bi_wait_timer.sv
module bi_wait_timer #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              arm_start,
    input  logic              arm_next,
    input  logic              tick,
    output logic              expired,
    output logic              cfg_zero
);
    typedef struct packed {
        logic [WAIT_W-1:0] cnt;
    } regs_t;

    regs_t tm_q, tm_d;

    assign cfg_zero = (wait_cfg == '0);

    always_comb begin
        tm_d = tm_q;
        if (arm_start) begin
            tm_d.cnt = wait_cfg;
        end else if (arm_next) begin
            // the cycle spent loading the next word is part of the wait
            tm_d.cnt = cfg_zero ? '0 : (wait_cfg - 1'b1);
        end else if (tick && (tm_q.cnt != '0)) begin
            tm_d.cnt = tm_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign expired = (tm_q.cnt == '0);
endmodule

// File: rtl/bi_rd_capture.sv
module bi_rd_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] ad_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] word;
    } regs_t;

    regs_t cap_q, cap_d;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = capture;
        if (capture) begin
            cap_d.word = ad_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rd_valid = cap_q.vld;
    assign rd_data  = cap_q.word;
endmodule

// File: rtl/bi_phase_ctrl.sv
module bi_phase_ctrl
    import bi_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_len_nz,
    input  logic              req_write,
    input  logic [LANES-1:0]  req_rd_be,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic              trdy_n,
    input  logic              last_beat,
    input  logic              wait_done,
    input  logic              wait_zero,
    output logic              accept,
    output logic              complete,
    output logic              wr_ready,
    output logic              wait_tick,
    output logic              busy,
    output logic              done,
    output logic              irdy_n,
    output logic              ad_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic [LANES-1:0]  cbe_n
);
    typedef struct packed {
        bi_state_e         st;
        logic              irdy;
        logic              oe;
        logic              is_wr;
        logic              done;
        logic [LANES-1:0]  rd_be;
        logic [LANES-1:0]  cbe_n;
        logic [DATA_W-1:0] ad;
    } regs_t;

    regs_t ph_q, ph_d;
    logic  word_avail;

    assign word_avail = ph_q.is_wr ? wr_valid : 1'b1;

    always_comb begin
        ph_d      = ph_q;
        ph_d.done = 1'b0;
        accept    = 1'b0;
        wr_ready  = 1'b0;
        wait_tick = 1'b0;
        complete  = (ph_q.st == ST_PHASE) && ph_q.irdy && !trdy_n;

        case (ph_q.st)
            ST_IDLE: begin
                if (req_valid && req_len_nz) begin
                    accept      = 1'b1;
                    ph_d.st     = ST_PHASE;
                    ph_d.is_wr  = req_write;
                    ph_d.rd_be  = req_rd_be;
                    ph_d.oe     = req_write;
                end
            end
            default: begin
                if (!ph_q.irdy) begin
                    if (!wait_done) begin
                        wait_tick = 1'b1;
                    end else if (word_avail) begin
                        ph_d.irdy  = 1'b1;
                        ph_d.cbe_n = ph_q.is_wr ? ~wr_be : ~ph_q.rd_be;
                        ph_d.ad    = ph_q.is_wr ? wr_data : ph_q.ad;
                        wr_ready   = ph_q.is_wr;
                    end
                end else if (complete) begin
                    if (last_beat) begin
                        ph_d.st    = ST_IDLE;
                        ph_d.irdy  = 1'b0;
                        ph_d.oe    = 1'b0;
                        ph_d.cbe_n = '1;
                        ph_d.done  = 1'b1;
                    end else if (wait_zero && word_avail) begin
                        ph_d.cbe_n = ph_q.is_wr ? ~wr_be : ~ph_q.rd_be;
                        ph_d.ad    = ph_q.is_wr ? wr_data : ph_q.ad;
                        wr_ready   = ph_q.is_wr;
                    end else begin
                        ph_d.irdy = 1'b0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q       <= '0;
            ph_q.st    <= ST_IDLE;
            ph_q.cbe_n <= '1;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign busy   = (ph_q.st == ST_PHASE);
    assign done   = ph_q.done;
    assign irdy_n = ~ph_q.irdy;
    assign ad_oe  = ph_q.oe;
    assign ad_out = ph_q.ad;
    assign cbe_n  = ph_q.cbe_n;
endmodule

// File: rtl/burst_initiator.sv
module burst_initiator #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int WAIT_W = 4,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [LANES-1:0]  req_rd_be,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              busy,
    output logic              done,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [LANES-1:0]  cbe_n,
    output logic              irdy_n,
    input  logic              trdy_n
);
    logic accept, complete, wait_tick;
    logic last_beat, wait_done, wait_zero;
    logic rd_capture;

    bi_phase_ctrl #(.DATA_W(DATA_W), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_len_nz (req_len != '0),
        .req_write  (req_write),
        .req_rd_be  (req_rd_be),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .wr_be      (wr_be),
        .trdy_n     (trdy_n),
        .last_beat  (last_beat),
        .wait_done  (wait_done),
        .wait_zero  (wait_zero),
        .accept     (accept),
        .complete   (complete),
        .wr_ready   (wr_ready),
        .wait_tick  (wait_tick),
        .busy       (busy),
        .done       (done),
        .irdy_n     (irdy_n),
        .ad_oe      (ad_oe),
        .ad_out     (ad_out),
        .cbe_n      (cbe_n)
    );

    bi_beat_counter #(.LEN_W(LEN_W)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_len (req_len),
        .step     (complete),
        .last     (last_beat)
    );

    bi_wait_timer #(.WAIT_W(WAIT_W)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_cfg  (wait_cfg),
        .arm_start (accept),
        .arm_next  (complete && !last_beat),
        .tick      (wait_tick),
        .expired   (wait_done),
        .cfg_zero  (wait_zero)
    );

    assign rd_capture = complete && !ad_oe;

    bi_rd_capture #(.DATA_W(DATA_W)) u_rdcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (rd_capture),
        .ad_in    (ad_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/bi_checker.sv
module bi_checker #(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irdy_n,
    input logic              trdy_n,
    input logic [DATA_W-1:0] ad_out,
    input logic [LANES-1:0]  cbe_n,
    input logic              ad_oe,
    input logic              busy,
    input logic              done,
    input logic              rd_valid,
    input logic              wr_ready
);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && trdy_n) |=> (!irdy_n && $stable(ad_out) && $stable(cbe_n)));

    p_rd_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!irdy_n && !trdy_n));

    p_done_after_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!irdy_n && !trdy_n));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (irdy_n && !ad_oe));

    p_take_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |=> (!irdy_n && ad_oe));
endmodule

bind burst_initiator bi_checker #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irdy_n   (irdy_n),
    .trdy_n   (trdy_n),
    .ad_out   (ad_out),
    .cbe_n    (cbe_n),
    .ad_oe    (ad_oe),
    .busy     (busy),
    .done     (done),
    .rd_valid (rd_valid),
    .wr_ready (wr_ready)
);

// File: tb/sim_burst_initiator.sv
module sim_burst_initiator;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_len = 8'd0;
    logic [3:0]  req_rd_be = 4'd0;
    logic [3:0]  wait_cfg = 4'd0;
    logic        busy, done;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_data = 32'd0;
    logic [3:0]  wr_be = 4'd0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [31:0] ad_out;
    logic        ad_oe;
    logic [31:0] ad_in = 32'd0;
    logic [3:0]  cbe_n;
    logic        irdy_n;
    logic        trdy_n = 1'b1;

    burst_initiator u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_len(req_len), .req_rd_be(req_rd_be), .wait_cfg(wait_cfg),
        .busy(busy), .done(done), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .wr_be(wr_be), .rd_valid(rd_valid), .rd_data(rd_data),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .cbe_n(cbe_n),
        .irdy_n(irdy_n), .trdy_n(trdy_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // burst configuration and monitor state
    bit   mon_en = 1'b0;
    bit   cur_wr, cur_gap;
    int   cur_len, cur_w, cur_tm;
    logic [7:0] cur_id;
    int   ncmp, nrd, ndone, wk;
    bit   pend_hs, prev_cmp, prev_last, prev_hold, wait_on;
    int   wait_cnt;
    logic [31:0] prev_ad;
    logic [3:0]  prev_cbe;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] wdata(input logic [7:0] id, input int k);
        logic [7:0] kb;
        kb = 8'(k);
        return {id, kb, ~id, kb ^ 8'h3C};
    endfunction

    function automatic logic [3:0] wbe(input logic [7:0] id, input int k);
        if (k % 4 == 2) return 4'b0000;
        return 4'(((k * 5 + int'(id)) % 15) + 1);
    endfunction

    function automatic logic [31:0] rword(input logic [7:0] id, input int k);
        return 32'h5000_0000 + {8'd0, id, 16'd0} + 32'(k);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            fails++;
            $display("FAIL R5 watchdog: actual=%0d cycles expected=burst completion", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (mon_en) begin
            // stimulus for the coming edge
            if (pend_hs) wk++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (cur_tm)
                0: trdy_n = 1'b0;
                1: trdy_n = cyc[0];
                2: trdy_n = (cyc % 3) != 0;
                default: trdy_n = lfsr[0];
            endcase
            ad_in    = trdy_n ? {16'hDEAD, 16'(cyc)} : rword(cur_id, ncmp);
            wr_data  = wdata(cur_id, wk);
            wr_be    = wbe(cur_id, wk);
            wr_valid = cur_wr && (wk < cur_len) && (!cur_gap || lfsr[5]);
            #1;
            // registered outputs from the previous edge
            if (rd_valid || (prev_cmp && !cur_wr)) begin
                chk(rd_valid == (prev_cmp && !cur_wr), "R6 rd_valid one cycle after read completion",
                    32'(rd_valid), 32'(prev_cmp && !cur_wr));
                if (rd_valid) begin
                    chk(rd_data == rword(cur_id, nrd), "R6 read word", rd_data, rword(cur_id, nrd));
                    nrd++;
                end
            end
            if (done || (prev_cmp && prev_last)) begin
                chk(done == (prev_cmp && prev_last), "R10 done after final phase",
                    32'(done), 32'(prev_cmp && prev_last));
                chk(!busy && irdy_n && !ad_oe, "R10 bus released",
                    {29'd0, busy, irdy_n, ad_oe}, 32'h2);
                if (done) ndone++;
            end
            if (prev_hold) begin
                chk(!irdy_n && ad_out == prev_ad && cbe_n == prev_cbe, "R4 hold while target waits",
                    {ad_out[27:0], cbe_n}, {prev_ad[27:0], prev_cbe});
            end
            if (wait_on) begin
                if (irdy_n) begin
                    wait_cnt++;
                end else begin
                    chk(wait_cnt == cur_w, (cur_w == 0) ? "R8 back-to-back phases" : "R9 wait cycles",
                        32'(wait_cnt), 32'(cur_w));
                    if (cur_wr && cur_w == 0)
                        chk(ad_out == wdata(cur_id, ncmp), "R8 next word on bus", ad_out, wdata(cur_id, ncmp));
                    wait_on = 1'b0;
                end
            end
            // what the coming edge will do
            prev_cmp  = !irdy_n && !trdy_n;
            prev_last = 1'b0;
            if (prev_cmp) begin
                prev_last = (ncmp == cur_len - 1);
                if (cur_wr) begin
                    chk(ad_oe && ad_out == wdata(cur_id, ncmp), "R3 write word on bus",
                        ad_out, wdata(cur_id, ncmp));
                    chk(cbe_n == ~wbe(cur_id, ncmp), "R2 write lane enables",
                        32'(cbe_n), 32'(~wbe(cur_id, ncmp)));
                    if (wbe(cur_id, ncmp) == 4'b0000)
                        chk(cbe_n == 4'b1111, "R7 empty-mask phase", 32'(cbe_n), 32'hF);
                end else begin
                    chk(!ad_oe && cbe_n == ~req_rd_be, "R2 read lane enables",
                        {27'd0, ad_oe, cbe_n}, {28'd0, ~req_rd_be});
                end
                ncmp++;
                if (!prev_last && !(cur_wr && cur_gap)) begin
                    wait_on  = 1'b1;
                    wait_cnt = 0;
                end
            end
            prev_hold = !irdy_n && trdy_n;
            prev_ad   = ad_out;
            prev_cbe  = cbe_n;
            pend_hs   = wr_valid && wr_ready;
        end
    end

    task automatic run_burst(input bit wr, input int len, input int w, input int tm,
                             input bit gap, input bit extra_req);
        @(negedge clk); #2;
        cur_id    = cur_id + 8'd1;
        cur_wr    = wr; cur_len = len; cur_w = w; cur_tm = tm; cur_gap = gap;
        ncmp = 0; nrd = 0; ndone = 0; wk = 0;
        pend_hs = 0; prev_cmp = 0; prev_last = 0; prev_hold = 0; wait_on = 0;
        wait_cfg  = 4'(w);
        req_write = wr;
        req_len   = 8'(len);
        req_rd_be = 4'(int'(cur_id) % 16);
        req_valid = 1'b1;
        @(negedge clk); #2;
        req_valid = 1'b0;
        if (extra_req) begin
            repeat (2) @(negedge clk);
            #2;
            req_len = 8'd7; req_valid = 1'b1;
            @(negedge clk); #2;
            req_valid = 1'b0; req_len = 8'(len);
        end
        for (int i = 0; i < 600 && ndone == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        #2;
        chk(ncmp == len, extra_req ? "R11 mid-burst request ignored" : "R5 R7 phase count",
            32'(ncmp), 32'(len));
        chk(ndone == 1, "R10 one done pulse", 32'(ndone), 32'd1);
        if (!wr) chk(nrd == len, "R6 read words delivered", 32'(nrd), 32'(len));
        chk(!busy, "R11 idle after burst", 32'(busy), 32'd0);
    endtask

    initial begin
        cur_id = 8'd0;
        repeat (3) @(negedge clk);
        chk(irdy_n && !ad_oe && cbe_n == 4'hF && !busy && !done && !rd_valid && !wr_ready,
            "R1 reset outputs", {25'd0, irdy_n, ad_oe, cbe_n[0], busy, done, rd_valid, wr_ready}, 32'h50);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irdy_n && !ad_oe && cbe_n == 4'hF && !busy && !done && !rd_valid,
            "R1 after reset", {26'd0, irdy_n, ad_oe, cbe_n[0], busy, done, rd_valid}, 32'h28);

        // zero-length request must be ignored
        #2;
        req_len = 8'd0; req_write = 1'b1; req_valid = 1'b1;
        @(negedge clk); #2;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && irdy_n, "R11 zero-length request ignored", {30'd0, busy, irdy_n}, 32'h1);

        mon_en = 1'b1;
        for (int wr = 0; wr < 2; wr++)
            for (int wi = 0; wi < 3; wi++)
                for (int tm = 0; tm < 4; tm++)
                    for (int li = 0; li < 3; li++)
                        run_burst(wr[0], (li == 0) ? 1 : (li == 1) ? 2 : 5,
                                  (wi == 0) ? 0 : (wi == 1) ? 1 : 3, tm, 1'b0, 1'b0);
        for (int wi = 0; wi < 2; wi++)
            for (int tm = 0; tm < 4; tm++)
                run_burst(1'b1, 6, wi * 2, tm, 1'b1, 1'b0);
        run_burst(1'b1, 5, 1, 1, 1'b0, 1'b1);
        run_burst(1'b0, 4, 0, 2, 1'b0, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule